// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sleep and Wakeup

This block turns the receive line of an asynchronous serial link into characters. A 16x oversampling enable, produced elsewhere, sets the timing. A character is a low start bit, then 8 or 9 character bits sent least significant bit first, then a high stop bit. When parity is on, the top character bit carries the parity. The block confirms the start bit at its centre and samples each later bit at its own centre. Each completed character is delivered with a one-cycle ready strobe, together with a parity-error flag and a framing-error flag.

The block also has a receiver sleep facility. Software pulses a sleep request, and from then on completed characters are not delivered. The hardware ends the sleep when the selected wakeup condition is seen. That condition is either a character whose top bit is 1 (address mark) or a full character time of continuous 1s on the line (idle). A configuration input decides where the count of idle 1s begins: right after the start bit, so that trailing 1s in the data count, or only after the stop bit. Baud-rate generation and register access are outside this block.

Top module: `wake_rx`

## Requirements
- R1: While the synchronous active-low reset is applied and in the cycle after it is released, `data_rdy`, `par_err`, `frm_err` and `idle_det` are 0, `data_out` is 0 and `awake` is 1.
- R2: With `cfg_nine`=0, a frame of one low start bit, 8 bits LSB first and a stop bit gives one `data_rdy` pulse. `data_out[7:0]` holds the 8 bits and `data_out[8]` is 0.
- R3: With `cfg_nine`=1, the frame carries 9 bits LSB first, and all 9 appear on `data_out[8:0]` with one `data_rdy` pulse.
- R4: With `cfg_par_en`=1, the top character bit (bit 7 or bit 8) is the parity bit. The total number of 1s in all character bits must be even when `cfg_par_odd`=0 and odd when it is 1. On a mismatch, `par_err` is 1 alongside the strobe. With `cfg_par_en`=0, `par_err` stays 0.
- R5: A low level that no longer holds at the eighth oversampling tick after it was first seen is a glitch. It produces no character, and the next proper frame is received correctly.
- R6: A stop bit sampled low sets `frm_err` with the strobe, and the character is still delivered.
- R7: `idle_det` pulses for one cycle after 160 (`cfg_nine`=0) or 176 (`cfg_nine`=1) consecutive oversampling ticks of a high line. It pulses again only after the line has gone low.
- R8: With `cfg_idle_after_stop`=0, the idle count runs through the character bits, so a character whose upper bits are 1s, followed by a short gap, can signal idle. With `cfg_idle_after_stop`=1, the count is held at zero until the stop bit has been sampled.
- R9: A `sleep_req` pulse drives `awake` to 0 from the next cycle. While asleep, completed characters give no `data_rdy`.
- R10: With `cfg_wake_addr`=1, a character received while asleep whose top bit (bit 7, or bit 8 when `cfg_nine`=1) is 1 ends the sleep. That character is delivered with `data_rdy`, and `awake` is 1 in the same cycle.
- R11: With `cfg_wake_addr`=0, the idle detection of R7 ends the sleep. With `cfg_wake_addr`=1, an idle line does not end it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_nine | input | 1 | 1 = 9-bit characters, 0 = 8-bit |
| cfg_par_en | input | 1 | 1 = top character bit is parity |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_wake_addr | input | 1 | 1 = address-mark wakeup, 0 = idle-line wakeup |
| cfg_idle_after_stop | input | 1 | 1 = idle count starts after the stop bit, 0 = after the start bit |
| sleep_req | input | 1 | One-cycle pulse that puts the receiver to sleep |
| data_out | output | 9 | Last delivered character |
| data_rdy | output | 1 | One-cycle strobe: new character on `data_out` |
| par_err | output | 1 | Parity mismatch for the delivered character |
| frm_err | output | 1 | Stop bit was low for the delivered character |
| idle_det | output | 1 | One-cycle pulse when an idle character is seen |
| awake | output | 1 | 1 when the receiver is not asleep |

## Verification
Two functions can fall in the same cycle: the address-mark wakeup and the delivery of the character that wakes the receiver. Both come from one character completion. The bench provokes this by sleeping the receiver and then sending characters with the top bit clear and with it set, both in directed order and in a random sequence. It judges the result against a bench model of the sleep state: for each frame it checks that exactly one strobe appears, that it carries the right data, and that `awake` has risen when the strobe arrives. A second overlap is idle counting running through character bits. This is judged by comparing the idle pulse count for the same frame-and-gap pattern under the two idle-count settings.

// File: rtl/wrx_pkg.sv
// Package: shared types of the wakeup-capable serial receiver.
// Assumes: nothing beyond IEEE 1800-2017.
package wrx_pkg;
    typedef enum logic [1:0] {
        RX_HUNT  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/wrx_sync.sv
// Module: multi-stage synchronizer for the asynchronous receive line.
// Assumes: STAGES >= 2; the line idles high, so every stage resets to 1.
module wrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the raw line through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/wrx_deframer.sv
// Module: start-bit qualification, centre sampling and character assembly.
// Assumes: tick is a one-cycle enable at OVS times the bit rate; rx is
// synchronized; configuration is stable while a frame is in progress.
// A start bit counts only if the line is still low OVS/2 ticks after the
// falling edge was seen. Every later bit is sampled OVS ticks after the
// previous sample. done pulses one cycle after the stop bit is sampled.
module wrx_deframer
    import wrx_pkg::*;
#(
    parameter int OVS      = 16,
    parameter int CHAR_MAX = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                rx,
    input  logic                cfg_nine,
    input  logic                cfg_par_en,
    input  logic                cfg_par_odd,
    output logic                done,
    output logic [CHAR_MAX-1:0] chr,
    output logic                perr,
    output logic                ferr,
    output logic                busy
);
    localparam int CW  = $clog2(OVS);
    localparam int BW  = $clog2(CHAR_MAX + 1);
    localparam int MID = OVS / 2 - 1;

    rx_state_e           st;
    logic [CW-1:0]       cnt;
    logic [BW-1:0]       idx;
    logic [BW-1:0]       last_idx;
    logic [CHAR_MAX-1:0] shr;

    assign last_idx = cfg_nine ? BW'(CHAR_MAX - 1) : BW'(CHAR_MAX - 2);
    assign busy     = (st != RX_HUNT);
    assign chr      = shr;

    // Receive state machine, advanced on each oversampling tick.
    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (!rst_n) begin
            st   <= RX_HUNT;
            cnt  <= '0;
            idx  <= '0;
            shr  <= '0;
            perr <= 1'b0;
            ferr <= 1'b0;
        end else if (tick) begin
            case (st)
                RX_HUNT: begin
                    if (!rx) begin
                        st  <= RX_START;
                        cnt <= '0;
                    end
                end
                RX_START: begin
                    if (cnt == CW'(MID)) begin
                        cnt <= '0;
                        if (!rx) begin
                            st  <= RX_DATA;
                            idx <= '0;
                            shr <= '0;
                        end else begin
                            st <= RX_HUNT;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt == CW'(OVS - 1)) begin
                        cnt      <= '0;
                        shr[idx] <= rx;
                        if (idx == last_idx) st <= RX_STOP;
                        else                 idx <= idx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt == CW'(OVS - 1)) begin
                        cnt  <= '0;
                        st   <= RX_HUNT;
                        done <= 1'b1;
                        ferr <= !rx;
                        perr <= cfg_par_en && ((^shr) != cfg_par_odd);
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= RX_HUNT;
            endcase
        end
    end

    // R2: a completed character is reported only after the stop state.
    p_done_from_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(st) == RX_STOP));

    // R5: data sampling begins only if the start bit was still low mid-bit.
    p_start_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_DATA && $past(st) == RX_START) |-> !$past(rx));
endmodule

// File: rtl/wrx_idle.sv
// Module: idle-character detector.
// Assumes: tick is the oversampling enable; busy is high while a frame is
// being received. It counts ticks of a high line and resets the count on
// any low level. With after_stop set, it also holds the count at zero while
// a frame is in progress. It pulses once per idle stretch.
module wrx_idle #(
    parameter int OVS      = 16,
    parameter int CHAR_MAX = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx,
    input  logic busy,
    input  logic cfg_nine,
    input  logic cfg_after_stop,
    output logic idle
);
    localparam int LIM_LONG  = OVS * (CHAR_MAX + 2);
    localparam int LIM_SHORT = OVS * (CHAR_MAX + 1);
    localparam int CW        = $clog2(LIM_LONG + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic          fired;

    assign lim = cfg_nine ? CW'(LIM_LONG - 1) : CW'(LIM_SHORT - 1);

    // Count high ticks toward one idle character; fire once per stretch.
    always_ff @(posedge clk) begin
        idle <= 1'b0;
        if (!rst_n) begin
            cnt   <= '0;
            fired <= 1'b0;
        end else if (!rx || (cfg_after_stop && busy)) begin
            cnt   <= '0;
            fired <= 1'b0;
        end else if (tick && !fired) begin
            if (cnt == lim) begin
                idle  <= 1'b1;
                fired <= 1'b1;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R7: an idle detection is a single-cycle pulse.
    p_idle_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> !idle);

    // R8: with counting after the stop bit, no idle is seen during a frame.
    p_idle_after_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_after_stop && busy) |=> !idle);
endmodule

// File: rtl/wrx_wake.sv
// Module: sleep state, wakeup decision and delivery registers.
// Assumes: done, chr, perr and ferr come from the deframer; idle comes from
// the idle detector. A sleep request overrides a wakeup in the same cycle.
// In address-mark mode, the waking character is delivered.
module wrx_wake #(
    parameter int CHAR_MAX = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                done,
    input  logic [CHAR_MAX-1:0] chr,
    input  logic                perr,
    input  logic                ferr,
    input  logic                idle,
    input  logic                cfg_nine,
    input  logic                cfg_wake_addr,
    input  logic                sleep_req,
    output logic [CHAR_MAX-1:0] data_out,
    output logic                data_rdy,
    output logic                par_err,
    output logic                frm_err,
    output logic                idle_det,
    output logic                awake
);
    logic asleep;
    logic msb;
    logic wake_hit;
    logic deliver;

    assign msb      = cfg_nine ? chr[CHAR_MAX-1] : chr[CHAR_MAX-2];
    assign wake_hit = asleep && (cfg_wake_addr ? (done && msb) : idle);
    assign deliver  = done && !sleep_req && (!asleep || (cfg_wake_addr && msb));
    assign awake    = !asleep;

    // Sleep state: set by software request, cleared by the wakeup condition.
    always_ff @(posedge clk) begin
        if (!rst_n)         asleep <= 1'b0;
        else if (sleep_req) asleep <= 1'b1;
        else if (wake_hit)  asleep <= 1'b0;
    end

    // Delivery registers and output strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out <= '0;
            data_rdy <= 1'b0;
            par_err  <= 1'b0;
            frm_err  <= 1'b0;
            idle_det <= 1'b0;
        end else begin
            data_rdy <= deliver;
            idle_det <= idle;
            if (deliver) begin
                data_out <= chr;
                par_err  <= perr;
                frm_err  <= ferr;
            end
        end
    end

    // R9: a strobe never appears while the receiver is asleep.
    p_rdy_awake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        data_rdy |-> awake);

    // R9: a sleep request takes effect on the next cycle.
    p_sleep_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> !awake);

    // R10: an address-marked character wakes and is delivered together.
    p_addr_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && done && cfg_wake_addr && msb && !sleep_req) |=> (data_rdy && awake));

    // R11: in address-mark mode only a completed character can wake.
    p_no_idle_wake_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && cfg_wake_addr && !done && !sleep_req) |=> !awake);
endmodule

// File: rtl/wake_rx.sv
// Module: top of the wakeup-capable asynchronous serial receiver.
// Assumes: tick16 is a one-cycle enable at OVS times the bit rate; the
// configuration inputs change only while the line is idle.
module wake_rx #(
    parameter int OVS         = 16,
    parameter int CHAR_MAX    = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick16,
    input  logic                rxd,
    input  logic                cfg_nine,
    input  logic                cfg_par_en,
    input  logic                cfg_par_odd,
    input  logic                cfg_wake_addr,
    input  logic                cfg_idle_after_stop,
    input  logic                sleep_req,
    output logic [CHAR_MAX-1:0] data_out,
    output logic                data_rdy,
    output logic                par_err,
    output logic                frm_err,
    output logic                idle_det,
    output logic                awake
);
    logic                rx_s;
    logic                done;
    logic [CHAR_MAX-1:0] chr;
    logic                perr;
    logic                ferr;
    logic                busy;
    logic                idle;

    wrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rxd),
        .dout  (rx_s)
    );

    wrx_deframer #(.OVS(OVS), .CHAR_MAX(CHAR_MAX)) u_defr (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick16),
        .rx          (rx_s),
        .cfg_nine    (cfg_nine),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .done        (done),
        .chr         (chr),
        .perr        (perr),
        .ferr        (ferr),
        .busy        (busy)
    );

    wrx_idle #(.OVS(OVS), .CHAR_MAX(CHAR_MAX)) u_idle (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick           (tick16),
        .rx             (rx_s),
        .busy           (busy),
        .cfg_nine       (cfg_nine),
        .cfg_after_stop (cfg_idle_after_stop),
        .idle           (idle)
    );

    wrx_wake #(.CHAR_MAX(CHAR_MAX)) u_wake (
        .clk           (clk),
        .rst_n         (rst_n),
        .done          (done),
        .chr           (chr),
        .perr          (perr),
        .ferr          (ferr),
        .idle          (idle),
        .cfg_nine      (cfg_nine),
        .cfg_wake_addr (cfg_wake_addr),
        .sleep_req     (sleep_req),
        .data_out      (data_out),
        .data_rdy      (data_rdy),
        .par_err       (par_err),
        .frm_err       (frm_err),
        .idle_det      (idle_det),
        .awake         (awake)
    );
endmodule

// File: tb/sim_wake_rx.sv
// Bench: random and directed frames, checked against bench-side models.
module sim_wake_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic       cfg_nine = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic       cfg_wake_addr = 1'b0, cfg_idle_after_stop = 1'b0;
    logic       sleep_req = 1'b0;
    logic [8:0] data_out;
    logic       data_rdy, par_err, frm_err, idle_det, awake;

    int nchk = 0, nerr = 0;
    int rdy_cnt = 0, idle_cnt = 0;
    logic [8:0] cap_data;
    logic cap_pe, cap_fe, cap_awake;
    bit done_flag = 0;
    logic [1:0] div = 2'd0;

    wake_rx u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_wake_addr(cfg_wake_addr), .cfg_idle_after_stop(cfg_idle_after_stop),
        .sleep_req(sleep_req), .data_out(data_out), .data_rdy(data_rdy),
        .par_err(par_err), .frm_err(frm_err), .idle_det(idle_det), .awake(awake)
    );

    always #5 clk = ~clk;

    // Oversampling enable: one cycle in four, so one bit lasts 64 clocks.
    always @(negedge clk) begin
        div    <= div + 2'd1;
        tick16 <= (div == 2'd3);
    end

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (data_rdy) begin
                rdy_cnt   <= rdy_cnt + 1;
                cap_data  <= data_out;
                cap_pe    <= par_err;
                cap_fe    <= frm_err;
                cap_awake <= awake;
            end
            if (idle_det) idle_cnt <= idle_cnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [8:0] mk_char(input logic [8:0] d, input bit nine,
                                           input bit pen, input bit podd);
        int nb = nine ? 9 : 8;
        logic [8:0] r = '0;
        logic p = podd;
        for (int k = 0; k < nb; k++) r[k] = d[k];
        if (pen) begin
            for (int k = 0; k < nb - 1; k++) p ^= d[k];
            r[nb-1] = p;
        end
        return r;
    endfunction

    task automatic line_bits(input logic v, input int n);
        rxd = v;
        repeat (n * 64) @(negedge clk);
    endtask

    task automatic send_frame(input logic [8:0] r, input bit nine, input logic stopb);
        int nb = nine ? 9 : 8;
        line_bits(1'b0, 1);
        for (int k = 0; k < nb; k++) line_bits(r[k], 1);
        line_bits(stopb, 1);
        rxd = 1'b1;
    endtask

    task automatic pulse_sleep();
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int r0, i0;
        bit model_asleep;
        void'($urandom(32'd20240611));

        // R1: reset state.
        repeat (4) @(negedge clk);
        chk("R1 rdy in reset", data_rdy, 0);
        chk("R1 awake in reset", awake, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 data after reset", data_out, 0);
        chk("R1 flags after reset", {par_err, frm_err, idle_det, data_rdy}, 0);
        chk("R1 awake after reset", awake, 1);
        line_bits(1'b1, 12);

        // R2/R3/R4/R6: random formats, data, parity faults and stop faults.
        for (int i = 0; i < 40; i++) begin
            bit nine = $urandom % 2;
            bit pen  = $urandom % 2;
            bit podd = $urandom % 2;
            bit bad_p = pen && (($urandom % 4) == 0);
            bit bad_s = (($urandom % 8) == 0);
            logic [8:0] d = 9'($urandom);
            logic [8:0] r;
            cfg_nine = nine; cfg_par_en = pen; cfg_par_odd = podd;
            r = mk_char(d, nine, pen, podd);
            if (bad_p) r[nine ? 8 : 7] = ~r[nine ? 8 : 7];
            r0 = rdy_cnt;
            send_frame(r, nine, !bad_s);
            line_bits(1'b1, 2);
            chk(nine ? "R3 one strobe" : "R2 one strobe", rdy_cnt - r0, 1);
            chk(nine ? "R3 data" : "R2 data", cap_data, r);
            chk("R4 parity flag", cap_pe, bad_p);
            chk("R6 framing flag", cap_fe, bad_s);
        end

        // R5: short low glitch, then a proper frame.
        cfg_nine = 0; cfg_par_en = 0; cfg_par_odd = 0;
        r0 = rdy_cnt;
        rxd = 1'b0;
        repeat (20) @(negedge clk);
        line_bits(1'b1, 2);
        chk("R5 glitch ignored", rdy_cnt - r0, 0);
        send_frame(9'h0A5, 0, 1'b1);
        line_bits(1'b1, 1);
        chk("R5 frame after glitch", rdy_cnt - r0, 1);
        chk("R5 data after glitch", cap_data, 9'h0A5);

        // R7: idle length in both character lengths (count after stop).
        cfg_idle_after_stop = 1;
        for (int n = 0; n < 2; n++) begin
            cfg_nine = n[0];
            send_frame(9'h000, n[0], 1'b1);
            i0 = idle_cnt;
            line_bits(1'b1, 9 + n);
            chk("R7 no idle before full time", idle_cnt - i0, 0);
            line_bits(1'b1, 1);
            chk("R7 idle after full time", idle_cnt - i0, 1);
            line_bits(1'b1, 12);
            chk("R7 single idle pulse", idle_cnt - i0, 1);
        end

        // R8: trailing 1s plus a short gap, under both count starts.
        cfg_nine = 0;
        for (int m = 0; m < 2; m++) begin
            cfg_idle_after_stop = m[0];
            send_frame(9'h000, 0, 1'b1);
            i0 = idle_cnt;
            send_frame(9'h0FF, 0, 1'b1);
            line_bits(1'b1, 2);
            send_frame(9'h000, 0, 1'b1);
            chk(m ? "R8 no false idle after stop" : "R8 false idle after start",
                idle_cnt - i0, m ? 0 : 1);
            line_bits(1'b1, 12);
        end

        // R9/R10: address-mark sleep and wake.
        cfg_wake_addr = 1; cfg_idle_after_stop = 1; cfg_nine = 0;
        pulse_sleep();
        chk("R9 asleep after request", awake, 0);
        r0 = rdy_cnt;
        send_frame(9'h012, 0, 1'b1);
        line_bits(1'b1, 1);
        chk("R9 unmarked char suppressed", rdy_cnt - r0, 0);
        line_bits(1'b1, 12);
        chk("R11 idle does not wake in address mode", awake, 0);
        send_frame(9'h085, 0, 1'b1);
        line_bits(1'b1, 1);
        chk("R10 marked char delivered", rdy_cnt - r0, 1);
        chk("R10 marked char data", cap_data, 9'h085);
        chk("R10 awake with strobe", cap_awake, 1);
        cfg_nine = 1;
        pulse_sleep();
        send_frame(9'h080, 1, 1'b1);
        line_bits(1'b1, 1);
        chk("R10 nine-bit bit7 does not wake", awake, 0);
        send_frame(9'h101, 1, 1'b1);
        line_bits(1'b1, 1);
        chk("R10 nine-bit mark wakes", awake, 1);
        chk("R10 nine-bit mark data", cap_data, 9'h101);

        // R11: idle-line wakeup.
        cfg_wake_addr = 0; cfg_nine = 0;
        send_frame(9'h000, 0, 1'b1);
        pulse_sleep();
        r0 = rdy_cnt;
        send_frame(9'h081, 0, 1'b1);
        send_frame(9'h07F, 0, 1'b1);
        chk("R11 chars suppressed while asleep", rdy_cnt - r0, 0);
        chk("R11 still asleep", awake, 0);
        line_bits(1'b1, 11);
        chk("R11 idle wakes", awake, 1);
        send_frame(9'h044, 0, 1'b1);
        line_bits(1'b1, 1);
        chk("R11 delivery after idle wake", rdy_cnt - r0, 1);
        chk("R11 data after idle wake", cap_data, 9'h044);

        // R9/R10: random sleep requests against a bench sleep model.
        cfg_wake_addr = 1;
        model_asleep = 0;
        for (int j = 0; j < 14; j++) begin
            logic [8:0] d = {1'b0, 8'($urandom)};
            bit exp_del;
            if (($urandom % 2) == 1) begin
                pulse_sleep();
                model_asleep = 1;
            end
            exp_del = !model_asleep || d[7];
            if (d[7]) model_asleep = 0;
            r0 = rdy_cnt;
            send_frame(d, 0, 1'b1);
            line_bits(1'b1, 1);
            chk("R9 random delivery", rdy_cnt - r0, exp_del);
            if (exp_del) chk("R10 random data", cap_data, d);
            chk("R10 random awake", awake, !model_asleep);
        end

        finish_run();
    end
endmodule